// File: doc/BRIEF.md
# Auto-Incrementing Indexed Register Port

This block gives a microprocessor access to many internal registers through two visible locations. An index register names the register that the next data access reaches. The processor reaches that index in one of two ways. It can write it directly through the index location. Or, once a configuration bit turns on latch mode, the index is captured from a multiplexed address/data bus. The capture happens on the falling edge of one of two address-latch strobes, and a second configuration bit picks which strobe.

Each data access ends with the low nibble of the index stepping forward, so a run of neighbouring registers can be walked without rewriting the index. Index zero is special. It maps to an external FIFO read port and never advances, so repeated reads drain the FIFO one byte at a time. A small bank of generic read/write registers and the configuration register stand behind the index, so the access path can be exercised on its own.

Top module: `idx_reg_port`

## Requirements
- R1: After reset the index reads 00h, the configuration register at index 10h reads 00h, and every bank register reads 00h.
- R2: With latch mode off, a write with `reg_sel` low loads `wdata` into the index, and a read with `reg_sel` low returns the index on `rdata`.
- R3: With `reg_sel` high, a write stores `wdata` into the bank register named by the index (indices 01h to 0Fh), and a read returns that register on `rdata`.
- R4: A data access (`reg_sel` high) uses the index as it stood when the strobe rose. The low nibble is incremented on the clock edge that first sees both `acc_rd` and `acc_wr` low, so the new index is visible one cycle after the strobe drops. The index holds still for as long as a strobe stays high.
- R5: The increment wraps from F to 0 inside the low nibble and leaves the upper nibble unchanged (1Fh becomes 10h, 0Fh becomes 00h).
- R6: At index 00h a data read returns `fifo_rdata`, pulses `fifo_pop` high for exactly one cycle per read, and leaves the index at 00h.
- R7: In latch mode, `ad_bus` is loaded into the index on a falling edge of `ale_a` when the strobe-select bit is 0, or of `ale_b` when it is 1. The new index is visible three clock edges after the first edge that samples the strobe low. A falling edge on the unselected strobe leaves the index unchanged.
- R8: In latch mode, a write with `reg_sel` low does not change the index.
- R9: The configuration register at index 10h holds latch mode in bit 0 and strobe select in bit 1, and its other bits read 0. Data writes at index 00h or at any index from 11h to FFh store nothing, and data reads there return 00h (index 00h returns `fifo_rdata`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_rd | input | 1 | Processor read strobe, may last several cycles |
| acc_wr | input | 1 | Processor write strobe, may last several cycles |
| reg_sel | input | 1 | 0 selects the index location, 1 the data location |
| wdata | input | 8 | Processor write data |
| rdata | output | 8 | Processor read data (combinational) |
| ad_bus | input | 8 | Multiplexed address/data bus sampled at index capture |
| ale_a | input | 1 | First address-latch strobe |
| ale_b | input | 1 | Second address-latch strobe |
| fifo_rdata | input | 8 | Data presented by the FIFO behind index 00h |
| fifo_pop | output | 1 | One-cycle pop request to that FIFO |

## Verification
A read result is combinational from the index, so the bench samples `rdata` 2 ns after raising the read strobe on a falling clock edge. A bank write lands on the first rising edge under the strobe. The index step lands on the rising edge after the strobe falls, so each access task ends one full cycle after lowering the strobe before the index is read again. An address-latch capture passes a three-flop synchronizer and then the index register, so after the strobe falls the bench waits five cycles with `ad_bus` held before it reads the index. `fifo_pop` is counted on rising edges and compared against the number of index-00h reads issued.

// File: rtl/idx_port_pkg.sv
// Shared definitions for the indexed register port.
// Assumes an index as wide as the data path.
package idx_port_pkg;
    // Bit positions inside the configuration register
    localparam int CFG_LATCH_BIT = 0;
    localparam int CFG_STRB_BIT  = 1;
    localparam int CFG_USED_BITS = 2;

    // One-cycle commands issued by the access controller
    typedef struct packed {
        logic bank_we;   // store wdata into the register named by the index
        logic idx_we;    // load wdata into the index
        logic fifo_pop;  // pop the FIFO behind index zero
        logic idx_adv;   // step the index low nibble
    } acc_cmd_t;
endpackage

// File: rtl/idx_strobe_capture.sv
// Synchronizes both address-latch strobes, picks one, and flags its falling edge.
// Assumes the bus stays stable for SYNC_STAGES+1 clocks after the strobe falls.
module idx_strobe_capture #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ale_a,
    input  logic ale_b,
    input  logic use_b,
    input  logic enable,
    output logic fall
);
    localparam int NUM_STROBES = 2;

    logic [NUM_STROBES-1:0] ale_in;
    logic [NUM_STROBES-1:0] fall_raw;

    assign ale_in = {ale_b, ale_a};

    for (genvar g = 0; g < NUM_STROBES; g++) begin : g_sync
        logic [SYNC_STAGES:0] chain_q;

        // Shift the strobe through the synchronizer chain
        always_ff @(posedge clk) begin
            if (!rst_n) chain_q <= '0;
            else        chain_q <= {chain_q[SYNC_STAGES-1:0], ale_in[g]};
        end

        assign fall_raw[g] = chain_q[SYNC_STAGES] & ~chain_q[SYNC_STAGES-1];
    end

    // Select the configured strobe and gate with latch mode
    always_comb begin
        fall = enable & (use_b ? fall_raw[1] : fall_raw[0]);
    end
endmodule

// File: rtl/idx_access_ctrl.sv
// Turns processor strobes into one-cycle commands.
// A data write lands when the strobe rises. The index step follows when it falls.
// Assumes acc_rd and acc_wr are not raised together.
module idx_access_ctrl
    import idx_port_pkg::*;
#(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             acc_rd,
    input  logic             acc_wr,
    input  logic             reg_sel,
    input  logic [IDX_W-1:0] idx,
    input  logic             latch_mode,
    output acc_cmd_t         cmd
);
    logic strobe;
    logic strobe_q;
    logic data_q;
    logic start;
    logic finish;
    logic idx_zero;

    assign strobe   = acc_rd | acc_wr;
    assign start    = strobe & ~strobe_q;
    assign finish   = ~strobe & strobe_q;
    assign idx_zero = (idx == '0);

    // Remember strobe level and whether the access targets the data location
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            data_q   <= 1'b0;
        end else begin
            strobe_q <= strobe;
            if (start) data_q <= reg_sel;
        end
    end

    // Decode commands from the strobe edges
    always_comb begin
        cmd.bank_we  = start & acc_wr & reg_sel & ~idx_zero;
        cmd.idx_we   = start & acc_wr & ~reg_sel & ~latch_mode;
        cmd.fifo_pop = start & acc_rd & reg_sel & idx_zero;
        cmd.idx_adv  = finish & data_q;
    end
endmodule

// File: rtl/idx_pointer.sv
// Holds the index register. Priority: strobe capture, then direct write, then nibble step.
// The step wraps the low nibble, keeps the upper bits and never leaves zero.
module idx_pointer #(
    parameter int IDX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cap,
    input  logic [IDX_W-1:0] cap_val,
    input  logic             we,
    input  logic [IDX_W-1:0] we_val,
    input  logic             adv,
    output logic [IDX_W-1:0] idx
);
    localparam int NIB_W = 4;

    logic [IDX_W-1:0] idx_q;
    logic [IDX_W-1:0] idx_step;
    logic [NIB_W-1:0] nib_next;

    // Compute the nibble-wrapped successor
    always_comb begin
        nib_next = idx_q[NIB_W-1:0] + 1'b1;
        if (idx_q == '0) idx_step = idx_q;
        else             idx_step = {idx_q[IDX_W-1:NIB_W], nib_next};
    end

    // Update the index by source priority
    always_ff @(posedge clk) begin
        if (!rst_n)   idx_q <= '0;
        else if (cap) idx_q <= cap_val;
        else if (we)  idx_q <= we_val;
        else if (adv) idx_q <= idx_step;
    end

    assign idx = idx_q;
endmodule

// File: rtl/idx_reg_bank.sv
// Generic read/write registers at indices 1..NUM_REGS-1 plus the configuration register.
// Index zero and unmapped indices store nothing and read zero.
module idx_reg_bank
    import idx_port_pkg::*;
#(
    parameter int          DATA_W   = 8,
    parameter int          NUM_REGS = 16,
    parameter logic [DATA_W-1:0] CFG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [DATA_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              latch_mode,
    output logic              strobe_sel
);
    logic [DATA_W-1:0]        regs [NUM_REGS];
    logic [CFG_USED_BITS-1:0] cfg_q;

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
        if (g == 0) begin : g_hole
            assign regs[g] = '0;
        end else begin : g_store
            // Store write data when this register is addressed
            always_ff @(posedge clk) begin
                if (!rst_n)                              regs[g] <= '0;
                else if (we && (addr == DATA_W'(g)))     regs[g] <= wdata;
            end
        end
    end

    // Configuration register holds the latch-mode and strobe-select bits
    always_ff @(posedge clk) begin
        if (!rst_n)                      cfg_q <= '0;
        else if (we && addr == CFG_ADDR) cfg_q <= wdata[CFG_USED_BITS-1:0];
    end

    // Read multiplexer over the bank and configuration register
    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_REGS; i++) begin
            if (addr == DATA_W'(i)) rdata = regs[i];
        end
        if (addr == CFG_ADDR) rdata = DATA_W'(cfg_q);
    end

    assign latch_mode = cfg_q[CFG_LATCH_BIT];
    assign strobe_sel = cfg_q[CFG_STRB_BIT];
endmodule

// File: rtl/idx_reg_port.sv
// Top of the indexed register port: strobe capture, access control, index and bank.
// Assumes synchronous processor strobes and a held bus during address capture.
module idx_reg_port
    import idx_port_pkg::*;
#(
    parameter int          DATA_W      = 8,
    parameter int          NUM_REGS    = 16,
    parameter int          SYNC_STAGES = 2,
    parameter logic [DATA_W-1:0] CFG_ADDR = 8'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_rd,
    input  logic              acc_wr,
    input  logic              reg_sel,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] ad_bus,
    input  logic              ale_a,
    input  logic              ale_b,
    input  logic [DATA_W-1:0] fifo_rdata,
    output logic              fifo_pop
);
    acc_cmd_t          cmd;
    logic [DATA_W-1:0] idx_q;
    logic [DATA_W-1:0] bank_rdata;
    logic              latch_mode;
    logic              strobe_sel;
    logic              ale_fall;

    idx_strobe_capture #(.SYNC_STAGES(SYNC_STAGES)) cap_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .ale_a  (ale_a),
        .ale_b  (ale_b),
        .use_b  (strobe_sel),
        .enable (latch_mode),
        .fall   (ale_fall)
    );

    idx_access_ctrl #(.IDX_W(DATA_W)) ctrl_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_rd     (acc_rd),
        .acc_wr     (acc_wr),
        .reg_sel    (reg_sel),
        .idx        (idx_q),
        .latch_mode (latch_mode),
        .cmd        (cmd)
    );

    idx_pointer #(.IDX_W(DATA_W)) ptr_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .cap     (ale_fall),
        .cap_val (ad_bus),
        .we      (cmd.idx_we),
        .we_val  (wdata),
        .adv     (cmd.idx_adv),
        .idx     (idx_q)
    );

    idx_reg_bank #(
        .DATA_W   (DATA_W),
        .NUM_REGS (NUM_REGS),
        .CFG_ADDR (CFG_ADDR)
    ) bank_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .we         (cmd.bank_we),
        .addr       (idx_q),
        .wdata      (wdata),
        .rdata      (bank_rdata),
        .latch_mode (latch_mode),
        .strobe_sel (strobe_sel)
    );

    // Route read data from the index, the FIFO port or the bank
    always_comb begin
        if (!reg_sel)          rdata = idx_q;
        else if (idx_q == '0)  rdata = fifo_rdata;
        else                   rdata = bank_rdata;
    end

    assign fifo_pop = cmd.fifo_pop;
endmodule

// File: rtl/idx_reg_port_chk.sv
// Checker for the indexed register port, bound into the top module.
module idx_reg_port_chk #(
    parameter int IDX_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] idx,
    input logic             cap,
    input logic             we,
    input logic             adv,
    input logic             pop,
    input logic             latch_mode
);
    // R4: without a command the index holds
    a_r4_idx_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (!cap && !we && !adv) |=> $stable(idx));

    // R5: a step keeps the upper nibble and adds one in the lower
    a_r5_nibble_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cap && !we && idx != '0) |=>
        (idx[IDX_W-1:4] == $past(idx[IDX_W-1:4])) && (idx[3:0] == $past(idx[3:0]) + 4'd1));

    // R6: index zero never advances
    a_r6_zero_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !cap && !we && idx == '0) |=> (idx == '0));

    // R6: pop lasts one cycle
    a_r6_pop_single: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> !pop);

    // R8: no direct index write in latch mode
    a_r8_latch_blocks_write: assert property (@(posedge clk) disable iff (!rst_n)
        latch_mode |-> !we);
endmodule

bind idx_reg_port idx_reg_port_chk #(.IDX_W(DATA_W)) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .idx        (idx_q),
    .cap        (ale_fall),
    .we         (cmd.idx_we),
    .adv        (cmd.idx_adv),
    .pop        (fifo_pop),
    .latch_mode (latch_mode)
);

// File: tb/idx_reg_port_tb_top.sv
module idx_reg_port_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       acc_rd = 1'b0, acc_wr = 1'b0, reg_sel = 1'b0;
    logic [7:0] wdata = '0, ad_bus = '0, fifo_rdata = '0;
    logic       ale_a = 1'b0, ale_b = 1'b0;
    logic [7:0] rdata;
    logic       fifo_pop;

    int n_checks = 0;
    int n_fail = 0;
    int pop_cnt = 0;
    bit done = 0;

    always #10 clk = ~clk;

    idx_reg_port dut_i (
        .clk(clk), .rst_n(rst_n), .acc_rd(acc_rd), .acc_wr(acc_wr),
        .reg_sel(reg_sel), .wdata(wdata), .rdata(rdata), .ad_bus(ad_bus),
        .ale_a(ale_a), .ale_b(ale_b), .fifo_rdata(fifo_rdata), .fifo_pop(fifo_pop)
    );

    always @(posedge clk) if (rst_n && fifo_pop) pop_cnt++;

    task automatic check(string req, logic [7:0] act, logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // Write with a strobe of len cycles, then idle one cycle for the index step
    task automatic do_write(logic sel, logic [7:0] d, int len = 1);
        @(negedge clk);
        reg_sel = sel; wdata = d; acc_wr = 1'b1;
        repeat (len) @(negedge clk);
        acc_wr = 1'b0;
        @(negedge clk);
    endtask

    // Read; rdata sampled 2 ns after the strobe rises
    task automatic do_read(logic sel, output logic [7:0] d);
        @(negedge clk);
        reg_sel = sel; acc_rd = 1'b1;
        #2 d = rdata;
        @(negedge clk);
        acc_rd = 1'b0;
        @(negedge clk);
    endtask

    task automatic ale_pulse(bit use_b, logic [7:0] v);
        @(negedge clk);
        ad_bus = v;
        if (use_b) ale_b = 1'b1; else ale_a = 1'b1;
        repeat (2) @(negedge clk);
        ale_a = 1'b0; ale_b = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [7:0] d;
        do_read(0, d); check("R1 index", d, 8'h00);
        do_write(0, 8'h10); do_read(1, d); check("R1 cfg", d, 8'h00);
        do_write(0, 8'h05); do_read(1, d); check("R1 bank", d, 8'h00);
    endtask

    task automatic t_direct;
        logic [7:0] d;
        do_write(0, 8'h03); do_read(0, d); check("R2 index write", d, 8'h03);
    endtask

    task automatic t_bank;
        logic [7:0] d;
        do_write(1, 8'hA5); do_write(1, 8'h5A);
        do_read(0, d); check("R4 step after two writes", d, 8'h05);
        do_write(0, 8'h03);
        do_read(1, d); check("R3 reg3", d, 8'hA5);
        do_read(1, d); check("R3 reg4", d, 8'h5A);
    endtask

    task automatic t_long_strobe;
        logic [7:0] d;
        do_write(0, 8'h03);
        @(negedge clk); reg_sel = 1'b1; acc_rd = 1'b1;
        for (int i = 0; i < 3; i++) begin
            #2 check("R4 pre-increment during strobe", rdata, 8'hA5);
            @(negedge clk);
        end
        acc_rd = 1'b0;
        @(negedge clk);
        do_read(0, d); check("R4 one step after long read", d, 8'h04);
        do_write(0, 8'h06); do_write(1, 8'h77, 4);
        do_read(0, d); check("R4 one step after long write", d, 8'h07);
    endtask

    task automatic t_wrap;
        logic [7:0] d;
        do_write(0, 8'h1F); do_write(1, 8'hEE);
        do_read(0, d); check("R5 1F wraps to 10", d, 8'h10);
        do_write(0, 8'h0F); do_write(1, 8'h3C);
        do_read(0, d); check("R5 0F wraps to 00", d, 8'h00);
        do_write(0, 8'h0F); do_read(1, d); check("R3 reg15", d, 8'h3C);
    endtask

    task automatic t_fifo;
        logic [7:0] d;
        int base;
        do_write(0, 8'h00);
        base = pop_cnt;
        fifo_rdata = 8'h91; do_read(1, d); check("R6 fifo read 1", d, 8'h91);
        fifo_rdata = 8'h92; do_read(1, d); check("R6 fifo read 2", d, 8'h92);
        fifo_rdata = 8'h93; do_read(1, d); check("R6 fifo read 3", d, 8'h93);
        check("R6 pop count", 8'(pop_cnt - base), 8'd3);
        do_read(0, d); check("R6 index frozen", d, 8'h00);
        do_write(1, 8'h44);
        do_read(0, d); check("R9 write at 00 keeps index", d, 8'h00);
        check("R6 no pop on write", 8'(pop_cnt - base), 8'd3);
    endtask

    task automatic t_unmapped;
        logic [7:0] d;
        do_write(0, 8'h40); do_write(1, 8'hFF);
        do_write(0, 8'h40); do_read(1, d); check("R9 unmapped reads zero", d, 8'h00);
    endtask

    task automatic t_latch;
        logic [7:0] d;
        do_write(0, 8'h10); do_write(1, 8'h01);
        do_write(0, 8'h07); do_read(0, d); check("R8 direct write ignored", d, 8'h11);
        ale_pulse(0, 8'h05); do_read(0, d); check("R7 capture on ale_a", d, 8'h05);
        ale_pulse(1, 8'h09); do_read(0, d); check("R7 ale_b ignored", d, 8'h05);
        ale_pulse(0, 8'h10); do_write(1, 8'hFF);
        ale_pulse(1, 8'h0A); do_read(0, d); check("R7 capture on ale_b", d, 8'h0A);
        ale_pulse(0, 8'h0C); do_read(0, d); check("R7 ale_a ignored", d, 8'h0A);
        ale_pulse(1, 8'h10); do_read(1, d); check("R9 cfg upper bits zero", d, 8'h03);
        ale_pulse(1, 8'h10); do_write(1, 8'h00);
        do_write(0, 8'h02); do_read(0, d); check("R2 direct write after latch off", d, 8'h02);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_direct();
        t_bank();
        t_long_strobe();
        t_wrap();
        t_fifo();
        t_unmapped();
        t_latch();
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule